// File: doc/BRIEF.md
# Write Progress Status Readback

This block sits in the read path of a byte-wide non-volatile memory whose writes are carried out by an internal self-timed programming cycle. While that cycle runs, the block swaps array data for a status byte on the data bus, so a host can find out when the write has finished just by reading. The top bit of the status byte is the complement of the top bit of the byte most recently written. The bit below it flips on every new read access. Once programming ends, reads return the stored data unchanged.

A read access is active only while both the chip-enable and output-enable inputs are low. The start of an access is taken from the first clock in which the combined strobe is found active. The toggle bit advances at most once per access, however many clocks the access lasts. Every read made during programming is answered with status; the block does not compare addresses. A write attempt rejected by protection does not start programming, so the protected-illegal-write flag forces array data to be returned and the toggle bit stays put.

Top module: `status_readback`

## Requirements
- R1: While no read access is active (chip-enable or output-enable high, or both), `rd_data` is all zeros.
- R2: During a read access while `prog_busy` is 0, `rd_data` equals `arr_data`.
- R3: During a read access while `prog_busy` is 1 and `prot_reject` is 0, bit 7 of `rd_data` is the complement of `poll_ref_bit`.
- R4: During status reads, bit 6 of `rd_data` is 1 on the first status access after reset and takes the opposite value on each later access that begins with status active.
- R5: During status reads, bits 5 down to 0 of `rd_data` are 0.
- R6: While `prot_reject` is 1, a read returns `arr_data` and does not advance the toggle bit, even when `prog_busy` is 1.
- R7: Once `prog_busy` falls, reads return true array data. The toggle value is kept, and alternation resumes from it in the next programming window.
- R8: The toggle bit advances on the start of an access and not on every clock. Bit 6 holds steady for the whole of an access, however long it lasts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| prog_busy | input | 1 | Internal programming cycle in progress |
| prot_reject | input | 1 | A write was refused because of protection |
| poll_ref_bit | input | 1 | Bit 7 of the byte most recently written |
| arr_data | input | 8 | Data read from the array |
| rd_data | output | 8 | Read data presented to the bus drivers |

## Verification
Two events can land in the same clock: the start of a read access and a change of `prog_busy`. The bench starts accesses in the very clock where busy rises or falls. It also raises busy partway through an access that began on array data. A behavioural access counter judges each case by whether status was active at the start of the access, and checks every bit field on every clock. Starting an access while protection has refused a write is provoked in the same way, to show that the toggle count does not move.

// File: rtl/status_readback_pkg.sv
package status_readback_pkg;
    // Source selected for the read data bus
    typedef enum logic [1:0] {
        RM_IDLE   = 2'd0,
        RM_ARRAY  = 2'd1,
        RM_STATUS = 2'd2
    } rd_mode_t;
endpackage

// File: rtl/srb_strobe_det.sv
// Combines the two active-low enables into a read strobe and flags the
// first clock of each access. Assumes the enables are synchronous to clk.
module srb_strobe_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic rd_act,
    output logic rd_start
);
    logic rd_prev_q;

    assign rd_act   = ~ce_n & ~oe_n;
    assign rd_start = rd_act & ~rd_prev_q;

    // Remember the strobe of the previous clock for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev_q <= 1'b0;
        else        rd_prev_q <= rd_act;
    end
endmodule

// File: rtl/srb_toggle.sv
// Toggle state for the progress bit. It flips once per qualified access start.
// tog_view shows the post-advance value in the start clock as well, so the
// bit stays steady for the whole access.
module srb_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic tog_view
);
    logic tog_q;

    assign tog_view = adv ? ~tog_q : tog_q;

    // Advance the toggle on each qualified access start
    always_ff @(posedge clk) begin
        if (!rst_n)   tog_q <= 1'b0;
        else if (adv) tog_q <= ~tog_q;
    end
endmodule

// File: rtl/srb_mux.sv
// Builds the read data from the selected source. Assumes POLL_POS and
// TOG_POS are distinct bit positions inside DATA_W.
module srb_mux
    import status_readback_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int POLL_POS = 7,
    parameter int TOG_POS  = 6
) (
    input  rd_mode_t            mode,
    input  logic                poll_ref,
    input  logic                tog_view,
    input  logic [DATA_W-1:0]   arr_data,
    output logic [DATA_W-1:0]   rd_data
);
    logic [DATA_W-1:0] status_word;

    // Lay out the status word bit by bit: poll, toggle, zeros elsewhere
    for (genvar i = 0; i < DATA_W; i++) begin : g_stat
        if (i == POLL_POS) begin : g_poll
            assign status_word[i] = ~poll_ref;
        end else if (i == TOG_POS) begin : g_tog
            assign status_word[i] = tog_view;
        end else begin : g_rsv
            assign status_word[i] = 1'b0;
        end
    end

    // Pick the bus source from the read mode
    always_comb begin
        unique case (mode)
            RM_ARRAY:  rd_data = arr_data;
            RM_STATUS: rd_data = status_word;
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/status_readback.sv
// Read-path status substitution for a self-timed write. While programming
// runs and no protection refusal is flagged, reads return a poll bit and a
// per-access toggle bit instead of array data. Assumes all inputs are
// synchronous to clk.
module status_readback
    import status_readback_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              prog_busy,
    input  logic              prot_reject,
    input  logic              poll_ref_bit,
    input  logic [DATA_W-1:0] arr_data,
    output logic [DATA_W-1:0] rd_data
);
    localparam int POLL_POS = DATA_W - 1;
    localparam int TOG_POS  = DATA_W - 2;

    logic     rd_act;
    logic     rd_start;
    logic     status_on;
    logic     tog_view;
    rd_mode_t mode;

    srb_strobe_det u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .oe_n     (oe_n),
        .rd_act   (rd_act),
        .rd_start (rd_start)
    );

    // Status replaces data only during a real programming cycle
    assign status_on = prog_busy & ~prot_reject;

    srb_toggle u_tog (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (rd_start & status_on),
        .tog_view (tog_view)
    );

    // Choose the read source for this clock
    always_comb begin
        if (!rd_act)        mode = RM_IDLE;
        else if (status_on) mode = RM_STATUS;
        else                mode = RM_ARRAY;
    end

    srb_mux #(
        .DATA_W   (DATA_W),
        .POLL_POS (POLL_POS),
        .TOG_POS  (TOG_POS)
    ) u_mux (
        .mode     (mode),
        .poll_ref (poll_ref_bit),
        .tog_view (tog_view),
        .arr_data (arr_data),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/status_readback_chk.sv
// Property checker bound to status_readback. It keeps its own access
// tracking, built from the ports only.
module status_readback_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              prog_busy,
    input logic              prot_reject,
    input logic              poll_ref_bit,
    input logic [DATA_W-1:0] arr_data,
    input logic [DATA_W-1:0] rd_data
);
    logic rd, stat;
    logic c_prev_rd, c_prev_stat, c_prev_tog, c_have;

    assign rd   = !ce_n && !oe_n;
    assign stat = rd && prog_busy && !prot_reject;

    // Track previous strobe, status and the last toggle value shown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_prev_rd   <= 1'b0;
            c_prev_stat <= 1'b0;
            c_prev_tog  <= 1'b0;
            c_have      <= 1'b0;
        end else begin
            c_prev_rd   <= rd;
            c_prev_stat <= stat;
            if (stat) begin
                c_prev_tog <= rd_data[DATA_W-2];
                c_have     <= 1'b1;
            end
        end
    end

    assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |-> rd_data == '0);
    assert_array_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !prog_busy) |-> rd_data == arr_data);
    assert_poll_inv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat |-> rd_data[DATA_W-1] == !poll_ref_bit);
    assert_tog_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && !c_prev_rd && c_have) |-> rd_data[DATA_W-2] != c_prev_tog);
    assert_rsv_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat |-> rd_data[DATA_W-3:0] == '0);
    assert_prot_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && prot_reject) |-> rd_data == arr_data);
    assert_tog_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat && c_prev_rd && c_prev_stat) |-> rd_data[DATA_W-2] == c_prev_tog);
endmodule

bind status_readback status_readback_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .prog_busy    (prog_busy),
    .prot_reject  (prot_reject),
    .poll_ref_bit (poll_ref_bit),
    .arr_data     (arr_data),
    .rd_data      (rd_data)
);

// File: tb/sim_status_readback.sv
module sim_status_readback;
    localparam int CLK_T = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, oe_n = 1'b1;
    logic       prog_busy = 1'b0, prot_reject = 1'b0, poll_ref_bit = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] rd_data;

    int total = 0;
    int bad = 0;
    int status_accesses = 0;
    bit was_reading = 0;
    bit done = 0;

    always #(CLK_T/2) clk = ~clk;

    status_readback u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
        .prog_busy(prog_busy), .prot_reject(prot_reject),
        .poll_ref_bit(poll_ref_bit), .arr_data(arr_data), .rd_data(rd_data)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: count status accesses; compare fields on every clock
    always @(negedge clk) begin
        bit reading, starting, status;
        reading  = !ce_n && !oe_n;
        starting = reading && !was_reading;
        status   = reading && prog_busy && !prot_reject;
        if (!rst_n) begin
            status_accesses = 0;
            was_reading = 0;
            check("R1 reset", rd_data, 8'h00);
        end else begin
            if (starting && status) status_accesses++;
            if (!reading)
                check("R1", rd_data, 8'h00);
            else if (prot_reject)
                check("R6", rd_data, arr_data);
            else if (!prog_busy)
                check("R2/R7", rd_data, arr_data);
            else begin
                check("R3", {7'b0, rd_data[7]}, {7'b0, !poll_ref_bit});
                check("R4/R8", {7'b0, rd_data[6]}, {7'b0, status_accesses[0]});
                check("R5", {2'b0, rd_data[5:0]}, 8'h00);
            end
            was_reading = reading;
        end
    end

    task automatic drive(input bit ce, input bit oe, input bit busy, input bit prot,
                         input bit pref, input logic [7:0] arr, input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            ce_n = ce; oe_n = oe; prog_busy = busy; prot_reject = prot;
            poll_ref_bit = pref; arr_data = arr;
        end
    endtask

    initial begin
        #(CLK_T * 100000);
        bad++; total++;
        $display("FAIL watchdog: got hang expected finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        drive(1, 1, 0, 0, 0, 8'h00, 3);
        @(posedge clk); #1; rst_n = 1'b1;
        // R1: no access, also with only one enable low
        drive(1, 1, 0, 0, 0, 8'h5A, 2);
        drive(0, 1, 1, 0, 0, 8'h5A, 2);
        drive(1, 0, 1, 0, 1, 8'hA5, 2);
        // R2: idle reads with various data
        drive(0, 0, 0, 0, 0, 8'hC3, 2);
        drive(1, 1, 0, 0, 0, 8'hC3, 1);
        drive(0, 0, 0, 0, 1, 8'h3C, 1);
        drive(1, 1, 0, 0, 0, 8'h00, 1);
        // R3/R4/R5: busy, several accesses of differing length
        drive(1, 1, 1, 0, 0, 8'hFF, 1);
        drive(0, 0, 1, 0, 0, 8'hFF, 1);
        drive(1, 1, 1, 0, 0, 8'hFF, 1);
        drive(0, 0, 1, 0, 1, 8'h81, 3);
        drive(1, 1, 1, 0, 1, 8'h81, 2);
        drive(0, 0, 1, 0, 0, 8'h7E, 1);
        drive(1, 1, 1, 0, 0, 8'h7E, 1);
        // R8: long access holds toggle
        drive(0, 0, 1, 0, 1, 8'h55, 8);
        drive(1, 1, 1, 0, 1, 8'h55, 1);
        // back-to-back accesses via oe only
        for (int j = 0; j < 4; j++) begin
            drive(0, 0, 1, 0, j[0], 8'hAA, 1);
            drive(0, 1, 1, 0, j[0], 8'hAA, 1);
        end
        // R6: protection refusal during busy, no advance
        drive(0, 0, 1, 1, 0, 8'h96, 2);
        drive(1, 1, 1, 1, 0, 8'h96, 1);
        drive(0, 0, 1, 1, 0, 8'h69, 1);
        drive(1, 1, 1, 0, 0, 8'h69, 1);
        drive(0, 0, 1, 0, 0, 8'h69, 1);
        drive(1, 1, 1, 0, 0, 8'h69, 1);
        // access start in the same clock busy falls (R7)
        drive(0, 0, 0, 0, 1, 8'h12, 2);
        drive(1, 1, 0, 0, 1, 8'h12, 1);
        // busy falls mid-access
        drive(0, 0, 1, 0, 1, 8'h34, 2);
        drive(0, 0, 0, 0, 1, 8'h34, 2);
        drive(1, 1, 0, 0, 1, 8'h34, 1);
        // access start in the same clock busy rises (new window, R7)
        drive(0, 0, 1, 0, 0, 8'h9C, 2);
        drive(1, 1, 1, 0, 0, 8'h9C, 1);
        // busy rises mid-access that began on array data
        drive(1, 1, 0, 0, 1, 8'hE7, 1);
        drive(0, 0, 0, 0, 1, 8'hE7, 2);
        drive(0, 0, 1, 0, 1, 8'hE7, 3);
        drive(1, 1, 1, 0, 1, 8'hE7, 1);
        drive(0, 0, 1, 0, 1, 8'hE7, 2);
        drive(1, 1, 0, 0, 0, 8'h00, 3);
        // R4: reset clears toggle, first status access shows 1 again
        drive(1, 1, 0, 0, 0, 8'h00, 1);
        @(posedge clk); #1; rst_n = 1'b0;
        drive(1, 1, 0, 0, 0, 8'h00, 2);
        @(posedge clk); #1; rst_n = 1'b1;
        drive(0, 0, 1, 0, 0, 8'h11, 2);
        drive(1, 1, 1, 0, 0, 8'h11, 1);
        drive(0, 0, 1, 0, 0, 8'h11, 2);
        drive(1, 1, 0, 0, 0, 8'h11, 2);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule